// File: doc/BRIEF.md
# I2C Byte-Stepped Master Engine

This block is an I2C bus master that software drives one byte at a time through four small registers: a control register, a mode/status register, a data register that doubles as the shift register, and an own-address register. Software places an address byte in the data register and sets the go and output-enable bits. The engine then produces a START and clocks out that byte. It samples the acknowledge slot and halts with SCL pulled low. A pending flag, and an interrupt when enabled, tells software the byte is done.

Each later step follows the same pattern. Software loads the next byte, or prepares to receive one. It may change the direction or the acknowledge policy. It then clears the pending flag to let the bus move again. Clearing the flag after dropping the go bit finishes the transfer with a STOP. Setting go again while the engine is halted starts a repeated START, which is the only way to change direction. The bus lines are open-drain: the block outputs a "pull low" request for each line and reads back the wired level.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset both line pull-downs are inactive, every register reads 0x00, and irq is low.
- R2: Output-enable is mode/status bit 4. While it is 0, writing go (mode/status bit 5) pulls neither line low, and busy (mode/status read bit 5) stays 0.
- R3: Writing the mode/status register with go=1 and output-enable=1 while idle produces a START. The engine then shifts out the data register MSB first as the address byte, then releases SDA for one acknowledge slot. An address byte holds the 7-bit target in bits 7:1 and the direction in bit 0, where 1 means read. SDA does not change while SCL is high during data bits.
- R4: After every byte and its acknowledge slot, pending (control bit 4) is set and SCL stays pulled low until software writes the control register with bit 4 = 0. Writing 1 to that bit has no effect. The irq output equals pending AND interrupt-enable (control bit 5).
- R5: While halted in transmit mode, a write to the data register (offset 2) puts its bit 7 on SDA before SCL is released.
- R6: Mode/status read bit 0 holds the SDA level sampled in the last acknowledge slot: 1 when the target did not acknowledge, 0 when it did.
- R7: Busy (mode/status read bit 5) goes to 1 on a START seen on the lines (SDA falling while SCL is high). It returns to 0 on a STOP (SDA rising while SCL is high).
- R8: Receive mode is mode/status bit 7 = 1. In that mode, bytes after the address byte are sampled into the data register MSB first. In the acknowledge slot the engine pulls SDA low (ACK) when acknowledge-enable (control bit 7) is 1, and releases it (NACK) when it is 0.
- R9: Clearing pending while go is 0 produces a STOP: SDA goes low, SCL is released, then SDA is released. The engine returns to idle with both lines released and busy at 0.
- R10: Writing the mode/status register with go=1 while halted arms a repeated START. The next pending clear releases SDA, raises SCL and issues a new START with the data register as the address byte, under the newly written direction.
- R11: If the engine releases SDA for a transmitted 1 and samples 0, it sets arbitration-lost (mode/status read bit 3), releases both lines, goes idle and sets pending. The next START clears the flag.
- R12: The own-address register (offset 3) stores the low 7 bits written and reads them back with bit 7 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 mode/status, 2 data, 3 own address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| sclLow | output | 1 | Pull SCL low when 1 |
| sdaLow | output | 1 | Pull SDA low when 1 |
| sclIn | input | 1 | Wired SCL level |
| sdaIn | input | 1 | Wired SDA level |

## Verification
The embedded properties check several rules on every cycle. SCL stays pulled low for as long as a byte is pending mid-transfer. SDA holds steady while SCL is high on data bits. Clocking never runs past the acknowledge slot, and busy is already up whenever a bit is clocked. The data register changes during a byte only through the shifter. Other behaviours need the scenarios in the bench, run against a behavioural target that acknowledges and returns data. These are the exact bytes seen on the wire, the ACK/NACK policy, the repeated-START direction change, the output-enable gate and the arbitration abort.

// File: rtl/i2cbe_pkg.sv
package i2cbe_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_LOW, S_HIGH, S_HOLD,
    S_RSLOW, S_RSHIGH, S_STOPLOW, S_STOPHIGH
  } phase_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic shiftEn;  // shift the sampled SDA into the data register
    logic ackCap;   // capture the acknowledge-slot level
    logic pendSet;  // a byte step is complete
    logic arbSet;   // arbitration lost
    logic rsTaken;  // repeated start accepted
  } strobe_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DATA = 2'd2;
  localparam logic [1:0] REG_OWN  = 2'd3;

endpackage

// File: rtl/i2cbe_ctrl.sv
module i2cbe_ctrl
  import i2cbe_pkg::*;
#(
  parameter int HALF = 4  // clk cycles per SCL half period, at least 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    kick,
  input  logic    pending,
  input  logic    goBit,
  input  logic    restartReq,
  input  logic    rxMode,
  input  logic    ackEn,
  input  logic    txBit,
  input  logic    sdaIn,
  output strobe_t strb,
  output logic    idle,
  output logic    quiet,
  output logic    inHigh,
  output logic    sclLow,
  output logic    sdaLow
);

  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW = 4;
  localparam logic [BW-1:0] ACK_SLOT = BW'(8);

  phase_e        state, nState;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitCnt, nBit;
  logic          byteTx, nByteTx;
  logic          sclDrive, sdaDrive;
  logic          tDone;

  assign tDone  = (timer == '0);
  assign idle   = (state == S_IDLE);
  assign quiet  = (state == S_IDLE) || (state == S_HOLD);
  assign inHigh = (state == S_HIGH);

  always_comb begin
    nState  = state;
    nBit    = bitCnt;
    nByteTx = byteTx;
    strb    = '0;
    case (state)
      S_IDLE:  if (kick) nState = S_START;
      S_START: if (tDone) begin
        nState = S_LOW; nBit = '0; nByteTx = 1'b1;
      end
      S_LOW:   if (tDone) nState = S_HIGH;
      S_HIGH:  if (tDone) begin
        if (bitCnt == ACK_SLOT) begin
          strb.ackCap  = 1'b1;
          strb.pendSet = 1'b1;
          nState       = S_HOLD;
        end else if (byteTx && txBit && !sdaIn) begin
          strb.arbSet  = 1'b1;
          strb.pendSet = 1'b1;
          nState       = S_IDLE;
        end else begin
          strb.shiftEn = 1'b1;
          nBit         = bitCnt + BW'(1);
          nState       = S_LOW;
        end
      end
      S_HOLD:  if (!pending) begin
        if (restartReq) begin
          strb.rsTaken = 1'b1;
          nState       = S_RSLOW;
        end else if (!goBit) begin
          nState = S_STOPLOW;
        end else begin
          nState = S_LOW; nBit = '0; nByteTx = !rxMode;
        end
      end
      S_RSLOW:    if (tDone) nState = S_RSHIGH;
      S_RSHIGH:   if (tDone) nState = S_START;
      S_STOPLOW:  if (tDone) nState = S_STOPHIGH;
      S_STOPHIGH: if (tDone) nState = S_IDLE;
      default:    nState = S_IDLE;
    endcase
  end

  // SCL follows the next phase; SDA lags the phase by one clock so it
  // only moves while SCL is low, or on purpose for START and STOP
  always_comb begin
    sclDrive = (nState == S_LOW) || (nState == S_HOLD) ||
               (nState == S_RSLOW) || (nState == S_STOPLOW);
    case (state)
      S_START, S_STOPLOW, S_STOPHIGH: sdaDrive = 1'b1;
      S_LOW, S_HIGH:
        sdaDrive = (bitCnt == ACK_SLOT) ? (!byteTx && ackEn) : (byteTx && !txBit);
      S_HOLD:
        sdaDrive = !goBit ? 1'b1 : (restartReq ? 1'b0 : (!rxMode && !txBit));
      default: sdaDrive = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      byteTx <= 1'b1;
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      state  <= nState;
      bitCnt <= nBit;
      byteTx <= nByteTx;
      sclLow <= sclDrive;
      sdaLow <= sdaDrive;
      if (nState != state)  timer <= TW'(HALF - 1);
      else if (!tDone)      timer <= timer - TW'(1);
    end
  end

  // R3: data bits never move while SCL is high
  p_sda_quiet_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HIGH && $past(state) == S_HIGH && bitCnt != ACK_SLOT) |-> $stable(sdaLow));

  // R3: clocking stops at the acknowledge slot
  p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= ACK_SLOT);

endmodule

// File: rtl/i2cbe_dp.sv
module i2cbe_dp
  import i2cbe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] wrData,
  input  strobe_t    strb,
  input  logic       idle,
  input  logic       quiet,
  input  logic       sdaIn,
  input  logic       sclIn,
  output logic [7:0] rdData,
  output logic       pending,
  output logic       goBit,
  output logic       restartReq,
  output logic       rxMode,
  output logic       ackEn,
  output logic       irqEn,
  output logic       outEn,
  output logic       txBit,
  output logic       kick,
  output logic       busy
);

  logic [7:0] dataReg;
  logic [6:0] ownAddr;
  logic       arbLost, lastBit, sdaPrev, sclPrev;
  logic       wrCtrl, wrStat, wrDat, wrOwn;

  assign wrCtrl = wrEn && (regAddr == REG_CTRL);
  assign wrStat = wrEn && (regAddr == REG_STAT);
  assign wrDat  = wrEn && (regAddr == REG_DATA);
  assign wrOwn  = wrEn && (regAddr == REG_OWN);
  assign kick   = wrStat && wrData[5] && wrData[4] && idle;
  assign txBit  = dataReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackEn <= 1'b0; irqEn <= 1'b0; pending <= 1'b0;
      rxMode <= 1'b0; goBit <= 1'b0; outEn <= 1'b0;
      restartReq <= 1'b0; arbLost <= 1'b0; lastBit <= 1'b0;
      dataReg <= '0; ownAddr <= '0;
      busy <= 1'b0; sdaPrev <= 1'b1; sclPrev <= 1'b1;
    end else begin
      if (wrCtrl) begin
        ackEn <= wrData[7];
        irqEn <= wrData[5];
        if (!wrData[4]) pending <= 1'b0;
      end
      if (strb.pendSet) pending <= 1'b1;

      if (wrStat) begin
        rxMode <= wrData[7];
        goBit  <= wrData[5];
        outEn  <= wrData[4];
        if (wrData[5] && quiet && !idle) restartReq <= 1'b1;
      end
      if (strb.rsTaken) restartReq <= 1'b0;
      if (kick)         arbLost    <= 1'b0;
      if (strb.arbSet) begin
        arbLost <= 1'b1;
        goBit   <= 1'b0;
      end
      if (strb.ackCap) lastBit <= sdaIn;

      if (wrDat && quiet)     dataReg <= wrData;
      else if (strb.shiftEn)  dataReg <= {dataReg[6:0], sdaIn};
      if (wrOwn)              ownAddr <= wrData[6:0];

      sdaPrev <= sdaIn;
      sclPrev <= sclIn;
      if (sclIn && sclPrev && sdaPrev && !sdaIn)      busy <= 1'b1;
      else if (sclIn && sclPrev && !sdaPrev && sdaIn) busy <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL: rdData = {ackEn, 1'b0, irqEn, pending, 4'b0};
      REG_STAT: rdData = {rxMode, 1'b0, busy, outEn, arbLost, 2'b0, lastBit};
      REG_DATA: rdData = dataReg;
      default:  rdData = {1'b0, ownAddr};
    endcase
  end

  // R4: pending only falls through a control write with bit 4 low
  p_pend_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !(wrCtrl && !wrData[4])) |=> pending);

  // R3: while a byte is on the wire the register moves only by shifting
  p_data_frozen_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!quiet && !strb.shiftEn) |=> $stable(dataReg));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2cbe_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       sclLow,
  output logic       sdaLow,
  input  logic       sclIn,
  input  logic       sdaIn
);

  strobe_t strb;
  logic idle, quiet, inHigh, sclInt, sdaInt;
  logic pending, goBit, restartReq, rxMode, ackEn, irqEn, outEn, txBit, kick, busy;

  i2cbe_dp u_dp (
    .clk, .rstN, .wrEn, .regAddr, .wrData, .strb, .idle, .quiet,
    .sdaIn, .sclIn, .rdData, .pending, .goBit, .restartReq, .rxMode,
    .ackEn, .irqEn, .outEn, .txBit, .kick, .busy
  );

  i2cbe_ctrl #(.HALF(HALF)) u_ctrl (
    .clk, .rstN, .kick, .pending, .goBit, .restartReq, .rxMode, .ackEn,
    .txBit, .sdaIn, .strb, .idle, .quiet, .inHigh,
    .sclLow(sclInt), .sdaLow(sdaInt)
  );

  assign sclLow = outEn && sclInt;
  assign sdaLow = outEn && sdaInt;
  assign irq    = pending && irqEn;

  // R4: a pending byte mid-transfer keeps the clock line held
  p_scl_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !idle && outEn) |-> sclLow);

  // R7: any clocked bit happens inside a START..STOP window
  p_busy_seen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inHigh && outEn) |-> busy);

endmodule

// File: tb/i2c_byte_engine_tb.sv
module i2c_byte_engine_tb;

  localparam logic [6:0] SLV = 7'h50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq, sclLow, sdaLow, sclIn, sdaIn;
  logic       slvLow = 1'b0;
  logic       jam = 1'b0;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign sclIn = ~sclLow;
  assign sdaIn = ~(sdaLow | slvLow | jam);

  i2c_byte_engine u_dut (
    .clk, .rstN, .wrEn, .regAddr, .wrData, .rdData, .irq,
    .sclLow, .sdaLow, .sclIn, .sdaIn
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural target + scoreboard monitor -------------
  logic [7:0] expQ[$];
  logic [7:0] slvTx[$];
  logic [7:0] rxSh = 8'd0, curTx = 8'hFF;
  int   bitCnt = 0;
  bit   inXfer = 0, addrPh = 0, rdPh = 0, rdDone = 0, doAck = 0, match = 0;
  logic mAck = 1'b1;

  always @(negedge sdaIn) if (sclIn === 1'b1) begin
    inXfer = 1; addrPh = 1; rdPh = 0; rdDone = 0; bitCnt = 0; slvLow = 1'b0;
  end

  always @(posedge sdaIn) if (sclIn === 1'b1) begin
    inXfer = 0; addrPh = 0; rdPh = 0; bitCnt = 0;
  end

  always @(posedge sclIn) if (inXfer) begin
    if (bitCnt < 8) rxSh = {rxSh[6:0], sdaIn};
    else begin
      mAck = sdaIn;
      if (rdPh && sdaIn) rdDone = 1;
    end
    bitCnt++;
    if (bitCnt == 8) begin
      if (!rdPh) begin
        if (expQ.size() == 0) chk(0, "R3 unexpected byte", rxSh, 0);
        else begin
          logic [7:0] e;
          e = expQ.pop_front();
          chk(rxSh == e, "R3 wire byte", rxSh, e);
        end
        if (addrPh) begin
          addrPh = 0;
          match  = (rxSh[7:1] == SLV);
          rdPh   = match && rxSh[0];
        end
        doAck = match;
      end else doAck = 0;
    end
  end

  always @(negedge sclIn) if (inXfer) begin
    if (bitCnt == 8) slvLow = doAck;
    else if (bitCnt == 9) begin
      bitCnt = 0;
      slvLow = 1'b0;
      if (rdPh && !rdDone) begin
        curTx  = (slvTx.size() != 0) ? slvTx.pop_front() : 8'hFF;
        slvLow = ~curTx[7];
      end
    end else if (rdPh && !rdDone && bitCnt > 0) slvLow = ~curTx[7-bitCnt];
  end

  // ---------------- driver tasks ----------------------------------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = rdData;
  endtask

  task automatic waitIrq(input string tag);
    int n = 0;
    while (irq !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(irq === 1'b1, tag, irq, 1);
  endtask

  task automatic waitFree(input string tag);
    logic [7:0] s;
    int n = 0;
    rd(2'd1, s);
    while (s[5] && n < 500) begin
      rd(2'd1, s);
      n++;
    end
    chk(s[5] == 1'b0, tag, s[5], 0);
  endtask

  // ---------------- scenarios -------------------------------------------
  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1 register reset", v, 0);
    end
    chk({irq, sclLow, sdaLow} == 3'b000, "R1 lines and irq", {irq, sclLow, sdaLow}, 0);

    // R12: own address keeps 7 bits
    wr(2'd3, 8'hAB);
    rd(2'd3, v);
    chk(v == 8'h2B, "R12 own address", v, 8'h2B);

    // R2: go without output enable does nothing on the lines
    wr(2'd2, 8'hA0);
    wr(2'd1, 8'h20);
    repeat (60) @(negedge clk);
    chk(sclLow == 1'b0 && sdaLow == 1'b0, "R2 lines idle", {sclLow, sdaLow}, 0);
    rd(2'd1, v);
    chk(v[5] == 1'b0, "R2 busy stays low", v[5], 0);
    wr(2'd1, 8'h00);

    // R3/R4/R5/R6/R7/R9: write two data bytes to an acknowledging target
    wr(2'd0, 8'hA0);
    expQ.push_back(8'hA0);
    wr(2'd1, 8'h30);
    waitIrq("R4 pending after address");
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R7 busy after START", v[5], 1);
    chk(v[0] == 1'b0, "R6 acknowledged address", v[0], 0);
    repeat (30) @(negedge clk);
    chk(sclLow == 1'b1 && irq == 1'b1, "R4 SCL held while pending", {sclLow, irq}, 3);
    wr(2'd0, 8'hB0);  // bit 4 = 1 must not clear pending
    repeat (10) @(negedge clk);
    chk(irq == 1'b1 && sclLow == 1'b1, "R4 writing one keeps pending", {irq, sclLow}, 3);
    wr(2'd2, 8'h3C);
    repeat (3) @(negedge clk);
    chk(sdaLow == 1'b1, "R5 bit7=0 drives SDA before release", sdaLow, 1);
    expQ.push_back(8'h3C);
    wr(2'd0, 8'hA0);
    waitIrq("R4 pending after data 1");
    wr(2'd2, 8'hC5);
    repeat (3) @(negedge clk);
    chk(sdaLow == 1'b0, "R5 bit7=1 releases SDA", sdaLow, 0);
    expQ.push_back(8'hC5);
    wr(2'd0, 8'hA0);
    waitIrq("R4 pending after data 2");
    rd(2'd1, v);
    chk(v[0] == 1'b0, "R6 data acknowledged", v[0], 0);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'hA0);
    waitFree("R7 busy clears after STOP");
    chk(sclLow == 1'b0 && sdaLow == 1'b0 && irq == 1'b0, "R9 lines released after STOP",
        {sclLow, sdaLow, irq}, 0);

    // R6/R4: unanswered address, irq masked while pending
    wr(2'd2, 8'h44);
    expQ.push_back(8'h44);
    wr(2'd1, 8'h30);
    waitIrq("R4 pending after NACKed address");
    rd(2'd1, v);
    chk(v[0] == 1'b1, "R6 NACK reads 1", v[0], 1);
    wr(2'd0, 8'h90);  // irq enable off, pending kept
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R4 irq masked", irq, 0);
    rd(2'd0, v);
    chk(v[4] == 1'b1, "R4 pending still set", v[4], 1);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'hA0);
    waitFree("R9 STOP after NACK");

    // R10/R8: write register index, repeated START, read two bytes
    slvTx.push_back(8'h5A);
    slvTx.push_back(8'hC3);
    wr(2'd2, 8'hA0);
    expQ.push_back(8'hA0);
    wr(2'd1, 8'h30);
    waitIrq("R10 address phase");
    wr(2'd2, 8'h01);
    expQ.push_back(8'h01);
    wr(2'd0, 8'hA0);
    waitIrq("R10 index byte");
    wr(2'd1, 8'hB0);
    wr(2'd2, 8'hA1);
    expQ.push_back(8'hA1);
    wr(2'd0, 8'hA0);
    waitIrq("R10 read address after repeated START");
    rd(2'd1, v);
    chk(v[0] == 1'b0 && v[5] == 1'b1, "R10 read address acknowledged, bus held",
        {v[5], v[0]}, 2);
    wr(2'd0, 8'hA0);
    waitIrq("R8 first read byte");
    rd(2'd2, v);
    chk(v == 8'h5A, "R8 first byte received", v, 8'h5A);
    chk(mAck == 1'b0, "R8 ACK driven with enable set", mAck, 0);
    wr(2'd0, 8'h20);
    waitIrq("R8 second read byte");
    rd(2'd2, v);
    chk(v == 8'hC3, "R8 second byte received", v, 8'hC3);
    chk(mAck == 1'b1, "R8 NACK with enable clear", mAck, 1);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h20);
    waitFree("R9 STOP after read");

    // R11: arbitration lost on a transmitted 1
    wr(2'd2, 8'hA0);
    expQ.push_back(8'hA0);
    wr(2'd1, 8'h30);
    wr(2'd0, 8'hA0);
    waitIrq("R11 address before contention");
    jam = 1'b1;
    wr(2'd2, 8'h80);
    wr(2'd0, 8'hA0);
    waitIrq("R11 pending on arbitration loss");
    rd(2'd1, v);
    chk(v[3] == 1'b1, "R11 arbitration-lost flag", v[3], 1);
    repeat (2) @(negedge clk);
    chk(sclLow == 1'b0 && sdaLow == 1'b0, "R11 lines released", {sclLow, sdaLow}, 0);
    jam = 1'b0;
    wr(2'd0, 8'hA0);
    waitFree("R11 bus free after contender leaves");

    chk(expQ.size() == 0, "R3 all expected bytes seen", expQ.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

endmodule